// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block is a 63-bit counter that advances once for each cycle in which a count strobe is high. The strobe is expected to come from a 100 MHz timebase. A limit register sits beside it. When the counter reaches the programmed compare value, the block raises a one-cycle match pulse and a wake pulse for the core. The match lands on the software-interrupt bit that belongs to the instance's kind.

The top bit of the count word is not counter state. It is a stored flag, and it reads back as 1 whenever it is set. The top bit of the limit word disables the interrupt.

The block is meant to be instantiated three times: once for the processor tick, once for the system tick and once for the hypervisor system tick. A parameter selects which software-interrupt bit the match drives. Checking the privilege of reads is left to the surrounding logic.

Top module: `tick_timer`

## Requirements
- R1: After reset the counter is 0 and the flag is 1, so `rd_data` reads 0x8000_0000_0000_0000. The compare is disarmed with its disable flag set, and `match_bits` and `wake` are 0.
- R2: With `cnt_wr` low, the counter (`rd_data[62:0]`) advances by one on each clock edge at which `tick_en` is high. It holds when `tick_en` is low.
- R3: A count write (`cnt_wr` high) takes effect on the next clock edge. That edge loads `wr_data[62:0]` into the counter and stores `wr_data[63]` as the flag. The load takes priority over a tick in the same cycle.
- R4: `rd_data[62:0]` always shows the running counter, and `rd_data[63]` shows the stored flag.
- R5: A limit write (`lim_wr` high) takes effect on the next clock edge. That edge stores `wr_data[63]` as the disable flag and `wr_data[62:0]` as the compare value. The write arms the compare when the disable flag is 0 and the compare value is nonzero. While armed, the tick edge that brings the counter to the compare value also raises the match for exactly one cycle.
- R6: A limit written with bit 63 set disarms the compare, and no match fires.
- R7: A limit written with a compare value of zero disarms the compare. No match fires even when the counter wraps through zero.
- R8: A limit is late when its compare value is less than or equal to the counter value in effect after the write edge. A late limit fires at the first later tick edge, with no wait for wraparound. Edges without a tick do not fire it.
- R9: A match disarms the compare. No further match occurs until the next limit write.
- R10: With `IS_SYS` = 0 a match drives `match_bits[0]`, the tick-match bit. With `IS_SYS` = 1 it drives `match_bits[1]`, the system-tick-match bit. `wake` pulses in the same cycle as the match.
- R11: The counter wraps from 0x7FFF_FFFF_FFFF_FFFF to 0. The wrap leaves the flag untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count strobe from the 100 MHz timebase |
| cnt_wr | input | 1 | Write strobe for the count word |
| lim_wr | input | 1 | Write strobe for the limit word |
| wr_data | input | 64 | Write data for either register |
| rd_data | output | 64 | Count read: running counter, with the flag in bit 63 |
| match_bits | output | 2 | Software-interrupt set pulse: bit 0 for tick, bit 1 for system tick |
| wake | output | 1 | Wake pulse to the core, raised together with the match |

## Verification
The bench programs limits that lie in the past. A design that only tests for equality would stay silent here until the counter wrapped. The bench also programs limits with the disable bit set and limits of zero. A design that ignores either case would fire a spurious interrupt, and a zero limit would fire as the counter wraps through zero.

The bench runs the counter past its first match to catch a compare that re-fires. It also runs the counter across the 63-bit wrap, where a design that folded the flag into the counter would carry into bit 63.

A tick instance and a system-tick instance run side by side, which shows a wrong routing of the match to the software-interrupt bits.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CNT_W  = 63,
  parameter bit IS_SYS = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cnt_wr,
  input  logic             lim_wr,
  input  logic [CNT_W:0]   wr_data,
  output logic [CNT_W:0]   rd_data,
  output logic [1:0]       match_bits,
  output logic             wake
);

  logic [CNT_W-1:0] cnt, cmp_val, cnt_nxt;
  logic             flag, dis, armed, late, hit, hit_nxt;
  logic             wr_arm;

  assign cnt_nxt = cnt_wr ? wr_data[CNT_W-1:0]
                          : cnt + {{(CNT_W-1){1'b0}}, tick_en};

  assign wr_arm  = !wr_data[CNT_W] && (wr_data[CNT_W-1:0] != '0);

  assign hit_nxt = !lim_wr && !cnt_wr && armed && tick_en &&
                   (late || (cnt_nxt == cmp_val));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      flag    <= 1'b1;
      dis     <= 1'b1;
      cmp_val <= '0;
      armed   <= 1'b0;
      late    <= 1'b0;
      hit     <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      hit <= hit_nxt;
      if (cnt_wr)
        flag <= wr_data[CNT_W];
      if (lim_wr) begin
        dis     <= wr_data[CNT_W];
        cmp_val <= wr_data[CNT_W-1:0];
        armed   <= wr_arm;
        late    <= wr_arm && (wr_data[CNT_W-1:0] <= cnt_nxt);
      end else if (hit_nxt) begin
        armed <= 1'b0;
        late  <= 1'b0;
      end
    end
  end

  assign rd_data    = {flag, cnt};
  assign match_bits = IS_SYS ? {hit, 1'b0} : {1'b0, hit};
  assign wake       = hit;

endmodule

module tick_timer_chk #(
  parameter int CNT_W = 63
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick_en,
  input logic           cnt_wr,
  input logic           lim_wr,
  input logic [CNT_W:0] wr_data,
  input logic [CNT_W:0] rd_data,
  input logic [1:0]     match_bits,
  input logic           wake,
  input logic           armed
);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cnt_wr) |=> $stable(rd_data));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !cnt_wr) |=>
      (rd_data[CNT_W-1:0] == $past(rd_data[CNT_W-1:0]) + 1'b1));

  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (rd_data == $past(wr_data)));

  a_r6_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_wr && (wr_data[CNT_W] || (wr_data[CNT_W-1:0] == '0))) |=> !armed);

  a_r9_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  a_r5_armed_src: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(armed));

  a_r10_routing: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_bits) && ((match_bits != 2'b00) == wake));

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_wr(cnt_wr),
  .lim_wr(lim_wr), .wr_data(wr_data), .rd_data(rd_data),
  .match_bits(match_bits), .wake(wake), .armed(armed)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, cnt_wr = 1'b0, lim_wr = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_t, rd_s;
  logic [1:0]  mb_t, mb_s;
  logic        wk_t, wk_s;

  int vectors = 0, miscompares = 0;
  int hits_t = 0, hits_s = 0, stray = 0, wakes = 0;

  always #4 clk = ~clk;

  tick_timer #(.CNT_W(63), .IS_SYS(1'b0)) u_tick_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_wr(cnt_wr),
    .lim_wr(lim_wr), .wr_data(wr_data), .rd_data(rd_t),
    .match_bits(mb_t), .wake(wk_t));

  tick_timer #(.CNT_W(63), .IS_SYS(1'b1)) u_tick_timer_s (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_wr(cnt_wr),
    .lim_wr(lim_wr), .wr_data(wr_data), .rd_data(rd_s),
    .match_bits(mb_s), .wake(wk_s));

  // behavioural reference
  logic [62:0] m_cnt, m_cmp;
  bit m_flag, m_dis, m_live, m_past, m_fire;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_flag = 1; m_dis = 1;
      m_live = 0; m_past = 0; m_fire = 0;
    end else begin
      logic [62:0] after;
      after = cnt_wr ? wr_data[62:0] : m_cnt + 63'(tick_en);
      m_fire = 0;
      if (lim_wr) begin
        m_dis  = wr_data[63];
        m_cmp  = wr_data[62:0];
        m_live = !m_dis && (m_cmp != 0);
        m_past = m_live && (m_cmp <= after);
      end else if (m_live && tick_en && !cnt_wr &&
                   (m_past || after == m_cmp)) begin
        m_fire = 1; m_live = 0; m_past = 0;
      end
      if (cnt_wr) m_flag = wr_data[63];
      m_cnt = after;
    end
  end

  always @(negedge clk) begin
    logic [63:0] exp_rd;
    if (rst_n) begin
      exp_rd = {m_flag, m_cnt};
      vectors++;
      if (rd_t !== exp_rd || rd_s !== exp_rd) begin
        miscompares++;
        $display("FAIL R4 rd_data tick=%h sys=%h expected %h", rd_t, rd_s, exp_rd);
      end
      vectors++;
      if (mb_t !== {1'b0, m_fire} || mb_s !== {m_fire, 1'b0} ||
          wk_t !== m_fire || wk_s !== m_fire) begin
        miscompares++;
        $display("FAIL R5 match tick=%b/%b sys=%b/%b expected fire=%b",
                 mb_t, wk_t, mb_s, wk_s, m_fire);
      end
      hits_t += int'(mb_t[0]);
      hits_s += int'(mb_s[1]);
      stray  += int'(mb_t[1]) + int'(mb_s[0]);
      wakes  += int'(wk_t);
    end
  end

  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_cnt(logic [63:0] d);
    cnt_wr = 1; wr_data = d; cyc(); cnt_wr = 0;
  endtask

  task automatic wr_lim(logic [63:0] d);
    lim_wr = 1; wr_data = d; cyc(); lim_wr = 0;
  endtask

  task automatic run(int n);
    tick_en = 1;
    for (int i = 0; i < n; i++) cyc();
    tick_en = 0;
  endtask

  initial begin
    fork
      begin
        repeat (3) cyc();
        check("R1 rd_data", rd_t, 64'h8000_0000_0000_0000);
        check("R1 match", {62'd0, mb_t}, 64'd0);
        rst_n = 1;
        cyc();
        check("R1 held", rd_t, 64'h8000_0000_0000_0000);
        run(5);
        check("R2 count", rd_t, 64'h8000_0000_0000_0005);
        cyc(); cyc();
        check("R2 hold", rd_t, 64'h8000_0000_0000_0005);
        wr_cnt(64'h0000_0000_0000_0100);
        check("R3 load", rd_t, 64'h0000_0000_0000_0100);
        wr_cnt(64'h8000_0000_0000_0007);
        check("R4 flag", rd_t, 64'h8000_0000_0000_0007);
        wr_lim(64'd10);
        run(3);
        check("R5 hits", 64'(hits_t), 64'd1);
        run(10);
        check("R9 one shot", 64'(hits_t), 64'd1);
        wr_lim(64'h8000_0000_0000_0016);
        run(5);
        check("R6 disabled", 64'(hits_t), 64'd1);
        wr_lim(64'd0);
        wr_cnt(64'h7FFF_FFFF_FFFF_FFFE);
        run(3);
        check("R11 wrap", rd_t, 64'h0000_0000_0000_0001);
        check("R7 zero limit", 64'(hits_t), 64'd1);
        wr_cnt(64'd100);
        wr_lim(64'd5);
        cyc(); cyc(); cyc();
        check("R8 no tick no fire", 64'(hits_t), 64'd1);
        run(1);
        check("R8 late fire", 64'(hits_t), 64'd2);
        run(4);
        check("R8 single", 64'(hits_t), 64'd2);
        check("R10 sys bit", 64'(hits_s), 64'd2);
        check("R10 stray bits", 64'(stray), 64'd0);
        check("R10 wake", 64'(wakes), 64'd2);
      end
      begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule